// File: doc/BRIEF.md
# Logic-Built AES Forward Substitution Byte Unit

This unit performs the AES forward byte substitution without a 256-entry lookup table. Each incoming byte goes through a linear change of basis into the tower field GF((2^4)^2). There its multiplicative inverse is formed from a handful of GF(2^4) multiplications and one GF(2^4) inversion. A second linear map brings the result back to the standard AES representation, and the AES affine step then yields the substituted byte. The subfield constant and both change-of-basis matrices are not entered as tables. They are found at elaboration time from the AES reduction polynomial, so the datapath holds only XOR networks and small subfield multipliers.

A parameter sets whether the path is purely combinational or has two register cuts. The first cut sits after the basis change and the second after the inversion. A valid flag travels with the data through the same registers. The unit takes one byte per clock and has no stalls, so it can serve as one lane of a wider round datapath.

Top module: `sbox_cf`

## Requirements
- R1: Whenever `out_valid` is high, `out_byte` equals the AES forward S-box of the byte that was accepted with it: GF(2^8) inverse modulo x^8+x^4+x^3+x+1 (zero maps to zero), then bit k of the result is a_k ^ a_(k+4) ^ a_(k+5) ^ a_(k+6) ^ a_(k+7) (indices mod 8) ^ bit k of 0x63. This holds for all 256 inputs.
- R2: Input byte 0x00 produces output byte 0x63.
- R3: With `PIPE_STAGES` = 2, `out_valid` is `in_valid` delayed by exactly two clocks. Every accepted byte yields exactly one result, in order, and no result appears without an accepted byte.
- R4: While `rst_n` is low, and in the first cycle after it rises, `out_valid` is 0.
- R5: A new byte can be accepted on every clock, with no gaps required between consecutive valid inputs.
- R6: With `PIPE_STAGES` = 0, the path is combinational: `out_valid` follows `in_valid` and `out_byte` is the substitution of `in_byte` in the same cycle. Any value of `PIPE_STAGES` other than 0 or 2 is rejected at elaboration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the valid pipeline |
| in_valid | input | 1 | Marks `in_byte` as a byte to substitute this cycle |
| in_byte | input | 8 | Byte to substitute |
| out_valid | output | 1 | Marks `out_byte` as a result |
| out_byte | output | 8 | Substituted byte |

## Verification
The checker assumes that `in_valid` holds known values and is kept low while reset is asserted, because the reset property and the latency property relate `out_valid` to earlier values of `in_valid`. The bench ties `in_valid` low through the whole reset period and changes inputs only on falling edges. The injectivity property assumes `in_byte` is known whenever `in_valid` is high, and the stimulus never drives unknowns. The sweeps cover every byte value back to back and also a pseudo-random sequence with idle gaps, so the latency and ordering rules are exercised both under full load and with bubbles.

// File: rtl/sbox_cf_pkg.sv
package sbox_cf_pkg;

   localparam int unsigned BYTE_W = 8;
   localparam int unsigned NIB_W  = 4;
   localparam logic [8:0]  AES_POLY = 9'h11B;
   localparam logic [7:0]  AFFINE_C = 8'h63;

   // GF(2^4) product, reduction by x^4 + x + 1
   function automatic logic [3:0] nib_mul(input logic [3:0] a, input logic [3:0] b);
      logic [3:0] acc;
      logic [3:0] sh;
      acc = '0;
      sh  = a;
      for (int i = 0; i < 4; i++) begin
         if (b[i]) acc = acc ^ sh;
         sh = {sh[2:0], 1'b0} ^ (sh[3] ? 4'b0011 : 4'b0000);
      end
      return acc;
   endfunction

   // a^14 = a^-1 in GF(2^4); zero stays zero
   function automatic logic [3:0] nib_inv(input logic [3:0] a);
      logic [3:0] p2, p3, p6, p12;
      p2  = nib_mul(a, a);
      p3  = nib_mul(p2, a);
      p6  = nib_mul(p3, p3);
      p12 = nib_mul(p6, p6);
      return nib_mul(p12, p2);
   endfunction

   // smallest l such that y^2 + y + l has no root in GF(2^4)
   function automatic logic [3:0] pick_lambda();
      logic [3:0] found;
      logic       hit;
      found = '0;
      for (int l = 15; l >= 1; l--) begin
         hit = 1'b0;
         for (int y = 0; y < 16; y++) begin
            if ((nib_mul(4'(y), 4'(y)) ^ 4'(y) ^ 4'(l)) == 4'h0) hit = 1'b1;
         end
         if (!hit) found = 4'(l);
      end
      return found;
   endfunction

   // product in GF((2^4)^2) with z^2 = z + lam; high nibble is the z term
   function automatic logic [7:0] cf_mul(input logic [7:0] a, input logic [7:0] b,
                                         input logic [3:0] lam);
      logic [3:0] hh;
      hh = nib_mul(a[7:4], b[7:4]);
      return {hh ^ nib_mul(a[7:4], b[3:0]) ^ nib_mul(a[3:0], b[7:4]),
              nib_mul(hh, lam) ^ nib_mul(a[3:0], b[3:0])};
   endfunction

   // smallest composite element that is a root of the AES polynomial
   function automatic logic [7:0] pick_root(input logic [3:0] lam);
      logic [7:0] root, pw, acc;
      root = '0;
      for (int c = 255; c >= 2; c--) begin
         pw  = 8'h01;
         acc = 8'h00;
         for (int k = 0; k <= 8; k++) begin
            if (AES_POLY[k]) acc = acc ^ pw;
            pw = cf_mul(pw, 8'(c), lam);
         end
         if (acc == 8'h00) root = 8'(c);
      end
      return root;
   endfunction

   // column i of the basis change is root^i
   function automatic logic [63:0] fwd_cols(input logic [3:0] lam);
      logic [63:0] cols;
      logic [7:0]  beta, pw;
      beta = pick_root(lam);
      pw   = 8'h01;
      cols = '0;
      for (int i = 0; i < 8; i++) begin
         cols[i*8 +: 8] = pw;
         pw = cf_mul(pw, beta, lam);
      end
      return cols;
   endfunction

   function automatic logic [7:0] apply_cols(input logic [63:0] cols, input logic [7:0] v);
      logic [7:0] acc;
      acc = '0;
      for (int i = 0; i < 8; i++) begin
         if (v[i]) acc = acc ^ cols[i*8 +: 8];
      end
      return acc;
   endfunction

   // inverse basis change: column j is the preimage of unit vector j
   function automatic logic [63:0] bwd_cols(input logic [63:0] fwd);
      logic [63:0] cols;
      logic [7:0]  m;
      cols = '0;
      for (int a = 0; a < 256; a++) begin
         m = apply_cols(fwd, 8'(a));
         for (int j = 0; j < 8; j++) begin
            if (m == 8'(1 << j)) cols[j*8 +: 8] = 8'(a);
         end
      end
      return cols;
   endfunction

endpackage

// File: rtl/sbox_stage.sv
module sbox_stage #(
   parameter int unsigned W   = 8,
   parameter bit          REG = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         in_v,
   input  logic [W-1:0] in_d,
   output logic         out_v,
   output logic [W-1:0] out_d
);
   generate
      if (REG) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               out_v <= 1'b0;
               out_d <= '0;
            end else begin
               out_v <= in_v;
               out_d <= in_d;
            end
         end
      end else begin : g_wire
         assign out_v = in_v;
         assign out_d = in_d;
      end
   endgenerate
endmodule

// File: rtl/sbox_lin_map.sv
module sbox_lin_map #(
   parameter logic [63:0] COLS = 64'h8040_2010_0804_0201
) (
   input  logic [7:0] x,
   output logic [7:0] y
);
   always_comb begin
      y = '0;
      for (int i = 0; i < 8; i++) begin
         if (x[i]) y = y ^ COLS[i*8 +: 8];
      end
   end
endmodule

// File: rtl/sbox_cf_inv.sv
module sbox_cf_inv
   import sbox_cf_pkg::*;
#(
   parameter logic [3:0] LAMBDA = 4'hC
) (
   input  logic [7:0] c_in,
   output logic [7:0] c_out
);
   logic [NIB_W-1:0] hi, lo, norm, norm_inv;

   assign hi = c_in[7:4];
   assign lo = c_in[3:0];

   // norm = lam*hi^2 + hi*lo + lo^2, an element of the subfield
   assign norm     = nib_mul(nib_mul(hi, hi), LAMBDA) ^ nib_mul(hi, lo) ^ nib_mul(lo, lo);
   assign norm_inv = nib_inv(norm);
   assign c_out    = {nib_mul(hi, norm_inv), nib_mul(hi ^ lo, norm_inv)};
endmodule

// File: rtl/sbox_affine.sv
module sbox_affine
   import sbox_cf_pkg::*;
(
   input  logic [7:0] a,
   output logic [7:0] b
);
   function automatic logic [7:0] ror8(input logic [7:0] v, input int unsigned k);
      return (v >> k) | (v << (8 - k));
   endfunction

   assign b = a ^ ror8(a, 4) ^ ror8(a, 5) ^ ror8(a, 6) ^ ror8(a, 7) ^ AFFINE_C;
endmodule

// File: rtl/sbox_cf.sv
module sbox_cf
   import sbox_cf_pkg::*;
#(
   parameter int unsigned PIPE_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [BYTE_W-1:0] in_byte,
   output logic              out_valid,
   output logic [BYTE_W-1:0] out_byte
);
   localparam bit          USE_REGS = (PIPE_STAGES == 2);
   localparam logic [3:0]  LAMBDA   = pick_lambda();
   localparam logic [63:0] TO_CF    = fwd_cols(LAMBDA);
   localparam logic [63:0] FROM_CF  = bwd_cols(TO_CF);

   generate
      if (PIPE_STAGES != 0 && PIPE_STAGES != 2) begin : g_bad_stages
         $error("sbox_cf: PIPE_STAGES must be 0 or 2");
      end
   endgenerate

   logic [BYTE_W-1:0] cf_a, cf_b, inv_a, inv_b, std_inv;
   logic              v_b, v_c;

   // basis change into the tower field
   sbox_lin_map #(.COLS(TO_CF)) u_to_cf (.x(in_byte), .y(cf_a));

   sbox_stage #(.W(BYTE_W), .REG(USE_REGS)) u_cut_map (
      .clk(clk), .rst_n(rst_n),
      .in_v(in_valid), .in_d(cf_a),
      .out_v(v_b), .out_d(cf_b)
   );

   sbox_cf_inv #(.LAMBDA(LAMBDA)) u_inv (.c_in(cf_b), .c_out(inv_a));

   sbox_stage #(.W(BYTE_W), .REG(USE_REGS)) u_cut_inv (
      .clk(clk), .rst_n(rst_n),
      .in_v(v_b), .in_d(inv_a),
      .out_v(v_c), .out_d(inv_b)
   );

   // back to the standard basis, then the affine step
   sbox_lin_map #(.COLS(FROM_CF)) u_from_cf (.x(inv_b), .y(std_inv));
   sbox_affine u_aff (.a(std_inv), .b(out_byte));

   assign out_valid = v_c;
endmodule

// File: rtl/sbox_cf_chk.sv
module sbox_cf_chk #(
   parameter int unsigned PIPE_STAGES = 2
) (
   input logic       clk,
   input logic       rst_n,
   input logic       in_valid,
   input logic [7:0] in_byte,
   input logic       out_valid,
   input logic [7:0] out_byte
);
   logic [1:0] since_rst;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) since_rst <= 2'd0;
      else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
   end

   generate
      if (PIPE_STAGES == 2) begin : g_piped
         assert_valid_lat_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (since_rst >= 2'd2) |-> (out_valid == $past(in_valid, 2)));

         assert_zero_to_63_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && in_byte == 8'h00) |=> ##1 (out_valid && out_byte == 8'h63));

         assert_distinct_R1: assert property (@(posedge clk) disable iff (!rst_n)
            (since_rst == 2'd3 && out_valid && $past(out_valid)
             && $past(in_byte, 2) != $past(in_byte, 3)) |-> (out_byte != $past(out_byte)));

         assert_reset_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(rst_n) |-> !out_valid);
      end else begin : g_comb
         assert_zero_to_63_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && in_byte == 8'h00) |-> (out_byte == 8'h63));

         assert_distinct_R1: assert property (@(posedge clk) disable iff (!rst_n)
            (since_rst != 2'd0 && out_valid && $past(out_valid)
             && in_byte != $past(in_byte)) |-> (out_byte != $past(out_byte)));
      end
   endgenerate
endmodule

bind sbox_cf sbox_cf_chk #(.PIPE_STAGES(PIPE_STAGES)) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
   .out_valid(out_valid), .out_byte(out_byte)
);

// File: tb/sbox_cf_tb.sv
module sbox_cf_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       in_valid = 1'b0;
   logic [7:0] in_byte = 8'h00;
   logic       out_valid, out_valid0;
   logic [7:0] out_byte, out_byte0;

   int n_cmp = 0;
   int n_bad = 0;
   int cyc = 0;

   logic [7:0] ref_tab [256];

   typedef struct {
      int         due;
      logic [7:0] exp;
      logic [7:0] inp;
      string      tag;
   } item_t;
   item_t q[$];

   always #10 clk = ~clk;   // 50 MHz
   always @(posedge clk) cyc <= cyc + 1;

   sbox_cf #(.PIPE_STAGES(2)) u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
      .out_valid(out_valid), .out_byte(out_byte)
   );

   sbox_cf #(.PIPE_STAGES(0)) u_dut0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
      .out_valid(out_valid0), .out_byte(out_byte0)
   );

   function automatic logic [7:0] gf8_mul(input logic [7:0] a, input logic [7:0] b);
      logic [7:0] acc = 8'h00;
      logic [7:0] sh = a;
      for (int i = 0; i < 8; i++) begin
         if (b[i]) acc ^= sh;
         sh = {sh[6:0], 1'b0} ^ (sh[7] ? 8'h1B : 8'h00);
      end
      return acc;
   endfunction

   function automatic logic [7:0] ref_sub(input logic [7:0] x);
      logic [7:0] inv = 8'h00;
      logic [7:0] r;
      for (int y = 1; y < 256; y++) begin
         if (gf8_mul(x, 8'(y)) == 8'h01) inv = 8'(y);
      end
      for (int k = 0; k < 8; k++) begin
         r[k] = inv[k] ^ inv[(k+4)%8] ^ inv[(k+5)%8] ^ inv[(k+6)%8] ^ inv[(k+7)%8]
                ^ (8'h63 >> k);
      end
      return r;
   endfunction

   task automatic check(input bit ok, input string tag, input logic [7:0] act,
                        input logic [7:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual=%02h expected=%02h (cycle %0d)", tag, act, exp, cyc);
      end
   endtask

   // driver: sets inputs, queues the expected pipelined result, checks the comb instance
   task automatic drive(input logic v, input logic [7:0] b, input string tag);
      @(negedge clk);
      in_valid = v;
      in_byte  = b;
      if (v) q.push_back('{due: cyc + 2, exp: ref_tab[b], inp: b, tag: tag});
      #1;
      check(out_valid0 == v, "R6 comb valid", {7'd0, out_valid0}, {7'd0, v});
      if (v) check(out_byte0 == ref_tab[b], "R6 comb byte", out_byte0, ref_tab[b]);
   endtask

   // monitor: pops expected items when due
   always @(negedge clk) begin
      item_t it;
      if (rst_n) begin
         if (q.size() > 0 && q[0].due == cyc) begin
            it = q.pop_front();
            if (!out_valid) check(1'b0, "R3 missing result", {7'd0, out_valid}, 8'h01);
            else check(out_byte == it.exp, it.tag, out_byte, it.exp);
         end else if (out_valid) begin
            check(1'b0, "R3 unexpected result", out_byte, 8'h00);
         end
      end
   end

   initial begin
      logic [7:0] lfsr;
      for (int x = 0; x < 256; x++) ref_tab[x] = ref_sub(8'(x));

      // R4: quiet during reset and in the first cycle after release
      repeat (3) @(negedge clk);
      check(out_valid == 1'b0, "R4 in reset", {7'd0, out_valid}, 8'h00);
      rst_n = 1'b1;
      @(negedge clk);
      check(out_valid == 1'b0, "R4 after release", {7'd0, out_valid}, 8'h00);

      // R2: isolated zero byte
      drive(1'b1, 8'h00, "R2 zero byte");
      drive(1'b0, 8'h00, "idle");
      drive(1'b0, 8'h00, "idle");
      drive(1'b0, 8'h00, "idle");

      // R1 and R5: every byte, one per clock
      for (int x = 0; x < 256; x++) drive(1'b1, 8'(x), "R1 R5 full sweep");
      drive(1'b0, 8'h00, "idle");
      drive(1'b0, 8'h00, "idle");

      // R1 and R3: pseudo-random bytes with idle gaps
      lfsr = 8'hA5;
      for (int k = 0; k < 300; k++) begin
         lfsr = {lfsr[6:0], 1'b0} ^ (lfsr[7] ? 8'h1D : 8'h00);
         drive(lfsr[0] | lfsr[3], lfsr ^ 8'(k), "R1 R3 gapped");
      end

      // boundary bytes, back to back
      drive(1'b1, 8'hFF, "R1 byte FF");
      drive(1'b1, 8'h01, "R1 byte 01");
      drive(1'b1, 8'h00, "R2 zero in burst");
      drive(1'b1, 8'h80, "R1 byte 80");
      repeat (5) drive(1'b0, 8'h00, "idle");

      // R3: all queued results delivered
      check(q.size() == 0, "R3 results outstanding", 8'(q.size()), 8'h00);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule